// File: doc/BRIEF.md
# Edge-Driven DFE Tap Adaptation Engine

This block sets the coefficients of a four-level (PAM4) decision feedback equalizer from information the clock-recovery edge slicers already produce, so no extra error slicers are needed. The equalizer has one first-post-cursor FIR tap per receiver slice (four slices) and one shared long-tail IIR tap with an amplitude and a time constant. Each valid beat presents, per slice, the edge-slicer bit and a six-deep history of thermometer-coded decisions. The block keeps only beats whose transition is symmetric about zero, turns the edge bit into a residual-ISI polarity, correlates that polarity with the sign of an older symbol, and accumulates the resulting up/down votes.

At the end of each vote window a code moves by one LSB toward the majority, holds on a tie and saturates at its ends. Each FIR code has its own window per slice; the IIR amplitude and time-constant codes pool the votes of all slices over a longer symbol count. The six 6-bit codes drive the analog tap DACs directly.

Top module: `dfe_edge_adapt`

## Requirements
- R1: During and after reset, before any window completes, every FIR code, the IIR amplitude code and the IIR time-constant code equal INIT_CODE (32).
- R2: A slice's beat contributes votes only when its two symbols around the edge mirror about zero, i.e. the ones-counts of history entry 0 (newer) and entry 1 (reference) sum to 3; any other slice-beat leaves every code unchanged.
- R3: The symbol sign is thermometer bit 1 (levels 000, 001, 011, 111 from lowest to highest); the residual polarity of a qualifying slice-beat is the edge bit XOR the sign of history entry 1.
- R4: A qualifying slice-beat votes its FIR code up when the residual polarity equals the sign of D-1 (history entry 2) and down otherwise.
- R5: Each slice owns an independent FIR code whose votes come only from that slice.
- R6: The IIR amplitude code is voted the same way using D-2 (history entry 3), pooled over all slices.
- R7: The IIR time-constant code is voted the same way using D-3 (history entry 4) when TC_SEL_D4 is 0, or D-4 (history entry 5) when it is 1.
- R8: A FIR window spans FIR_WIN valid beats (256); an IIR window spans IIR_WIN/NSLICE valid beats (1024 symbols, 256 beats); beats with in_valid low neither vote nor advance a window.
- R9: On the clock edge that ends a window, the code steps +1 if its window vote sum is positive, -1 if negative, and holds if zero; the new value is visible from the next cycle, and codes never change at any other edge.
- R10: A code at 63 does not rise and a code at 0 does not fall; they never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Beat qualifier for edge_bits and dec_hist |
| edge_bits | input | NSLICE | Edge-slicer bit per slice |
| dec_hist | input | NSLICE*6*3 | Per slice, six thermometer decisions: 0 newer, 1 reference, 2..5 D-1..D-4 |
| fir_code | output | NSLICE*CODE_W | Per-slice FIR tap code |
| iir_amp_code | output | CODE_W | Shared IIR amplitude code |
| iir_tc_code | output | CODE_W | Shared IIR time-constant code |

## Verification
With default parameters the FIR and IIR windows both close on the same valid beat, so all six codes may step on one edge, each from a different history entry and vote population. Directed beats give each slice a different D-1 correlation (always agree, always disagree, balanced) while D-2 agrees and D-3 disagrees with D-4 set opposite, so one edge must raise, lower and hold different codes at once. Randomized beats with idle gaps follow, and long runs drive codes against 63 and 0 so saturation coincides with a window close; a scoreboard compares all six codes after every beat.

// File: rtl/dfe_adapt_pkg.sv
package dfe_adapt_pkg;

    typedef logic [2:0] therm_t;

    typedef struct packed {
        logic act;
        logic up;
    } vote_t;

    localparam int HIST_N = 6;
    localparam int H_NEW  = 0;
    localparam int H_REF  = 1;
    localparam int H_M1   = 2;
    localparam int H_M2   = 3;
    localparam int H_M3   = 4;
    localparam int H_M4   = 5;

    function automatic logic therm_sign(therm_t t);
        return t[1];
    endfunction

    function automatic logic [1:0] therm_level(therm_t t);
        return 2'(t[0]) + 2'(t[1]) + 2'(t[2]);
    endfunction

    function automatic logic is_mirror(therm_t a, therm_t b);
        return (3'(therm_level(a)) + 3'(therm_level(b))) == 3'd3;
    endfunction

    function automatic vote_t make_vote(logic ok, logic resid, logic past_sign);
        vote_t v;
        v.act = ok;
        v.up  = (resid == past_sign);
        return v;
    endfunction

endpackage

// File: rtl/edge_corr.sv
module edge_corr
    import dfe_adapt_pkg::*;
#(
    parameter bit TC_SEL_D4 = 1'b0
) (
    input  logic                edge_b,
    input  therm_t [HIST_N-1:0] hist,
    output vote_t               fir_v,
    output vote_t               amp_v,
    output vote_t               tc_v
);

    logic qual;
    logic resid;
    logic tc_sign;
    logic unused_outer;

    assign unused_outer = ^{hist[H_M1][0], hist[H_M1][2], hist[H_M2][0], hist[H_M2][2],
                            hist[H_M3][0], hist[H_M3][2], hist[H_M4][0], hist[H_M4][2]};

    always_comb begin
        qual    = is_mirror(hist[H_NEW], hist[H_REF]);
        resid   = edge_b ^ therm_sign(hist[H_REF]);
        tc_sign = TC_SEL_D4 ? therm_sign(hist[H_M4]) : therm_sign(hist[H_M3]);
        fir_v   = make_vote(qual, resid, therm_sign(hist[H_M1]));
        amp_v   = make_vote(qual, resid, therm_sign(hist[H_M2]));
        tc_v    = make_vote(qual, resid, tc_sign);
    end

    // a counted beat is always a real sign change across the edge
    always_comb begin
        if (fir_v.act) begin
            assert_mirror_flip_R2: assert (hist[H_NEW][1] != hist[H_REF][1]);
        end
    end

endmodule

// File: rtl/vote_window.sv
module vote_window
    import dfe_adapt_pkg::*;
#(
    parameter int NV        = 1,
    parameter int WIN_BEATS = 256,
    parameter int CODE_W    = 6,
    parameter int INIT_CODE = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  vote_t [NV-1:0]    votes,
    output logic [CODE_W-1:0] code
);

    localparam int CNT_W = (WIN_BEATS > 1) ? $clog2(WIN_BEATS) : 1;
    localparam int ACC_W = $clog2(NV * WIN_BEATS + 1) + 2;
    localparam logic [CODE_W-1:0]       CODE_MAX = '1;
    localparam logic [CNT_W-1:0]        CNT_LAST = CNT_W'(WIN_BEATS - 1);
    localparam logic signed [ACC_W-1:0] P_ONE    = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] M_ONE    = -ACC_W'(1);

    logic [CNT_W-1:0]        cnt_q;
    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] delta;
    logic signed [ACC_W-1:0] acc_w;
    logic                    last;
    logic                    go_up;
    logic                    go_dn;

    always_comb begin
        delta = '0;
        for (int i = 0; i < NV; i++) begin
            if (votes[i].act) begin
                delta = delta + (votes[i].up ? P_ONE : M_ONE);
            end
        end
        acc_w = acc_q + delta;
        last  = in_valid && (cnt_q == CNT_LAST);
        go_up = !acc_w[ACC_W-1] && (acc_w != '0);
        go_dn = acc_w[ACC_W-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            acc_q <= '0;
            code  <= CODE_W'(INIT_CODE);
        end else if (in_valid) begin
            if (last) begin
                cnt_q <= '0;
                acc_q <= '0;
                if (go_up && code != CODE_MAX) begin
                    code <= code + 1'b1;
                end else if (go_dn && code != '0) begin
                    code <= code - 1'b1;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
                acc_q <= acc_w;
            end
        end
    end

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(code));

    assert_one_lsb_R9: assert property (@(posedge clk) disable iff (rst)
        last |=> (code == $past(code)) ||
                 ({1'b0, code} == {1'b0, $past(code)} + 7'd1) ||
                 ({1'b0, code} + 7'd1 == {1'b0, $past(code)}));

    assert_tie_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (last && acc_w == '0) |=> $stable(code));

    assert_top_sat_R10: assert property (@(posedge clk) disable iff (rst)
        (last && code == CODE_MAX) |=> code != '0);

    assert_floor_sat_R10: assert property (@(posedge clk) disable iff (rst)
        (last && code == '0) |=> code != CODE_MAX);

endmodule

// File: rtl/dfe_edge_adapt.sv
module dfe_edge_adapt
    import dfe_adapt_pkg::*;
#(
    parameter int NSLICE    = 4,
    parameter int CODE_W    = 6,
    parameter int FIR_WIN   = 256,
    parameter int IIR_WIN   = 1024,
    parameter bit TC_SEL_D4 = 1'b0,
    parameter int INIT_CODE = 32
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              in_valid,
    input  logic [NSLICE-1:0]                 edge_bits,
    input  logic [NSLICE-1:0][HIST_N-1:0][2:0] dec_hist,
    output logic [NSLICE-1:0][CODE_W-1:0]     fir_code,
    output logic [CODE_W-1:0]                 iir_amp_code,
    output logic [CODE_W-1:0]                 iir_tc_code
);

    localparam int IIR_BEATS = IIR_WIN / NSLICE;

    vote_t [NSLICE-1:0] fir_votes;
    vote_t [NSLICE-1:0] amp_votes;
    vote_t [NSLICE-1:0] tc_votes;

    for (genvar g = 0; g < NSLICE; g++) begin : g_slice
        edge_corr #(.TC_SEL_D4(TC_SEL_D4)) u_corr (
            .edge_b (edge_bits[g]),
            .hist   (dec_hist[g]),
            .fir_v  (fir_votes[g]),
            .amp_v  (amp_votes[g]),
            .tc_v   (tc_votes[g])
        );

        vote_window #(
            .NV(1), .WIN_BEATS(FIR_WIN), .CODE_W(CODE_W), .INIT_CODE(INIT_CODE)
        ) u_fir (
            .clk      (clk),
            .rst      (rst),
            .in_valid (in_valid),
            .votes    (fir_votes[g:g]),
            .code     (fir_code[g])
        );
    end

    vote_window #(
        .NV(NSLICE), .WIN_BEATS(IIR_BEATS), .CODE_W(CODE_W), .INIT_CODE(INIT_CODE)
    ) u_amp (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .votes    (amp_votes),
        .code     (iir_amp_code)
    );

    vote_window #(
        .NV(NSLICE), .WIN_BEATS(IIR_BEATS), .CODE_W(CODE_W), .INIT_CODE(INIT_CODE)
    ) u_tc (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .votes    (tc_votes),
        .code     (iir_tc_code)
    );

endmodule

// File: tb/tb_dfe_edge_adapt.sv
`timescale 1ns/1ps
module tb_dfe_edge_adapt;

    typedef logic [5:0][2:0] hist_t;
    typedef struct {
        int    fir [4];
        int    amp;
        int    tc;
        string tag;
    } exp_t;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic [3:0]          edge_bits = '0;
    logic [3:0][5:0][2:0] dec_hist = '0;
    logic [3:0][5:0]     fir_code;
    logic [5:0]          iir_amp_code;
    logic [5:0]          iir_tc_code;

    always #4 clk = ~clk;

    dfe_edge_adapt dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .edge_bits(edge_bits),
        .dec_hist(dec_hist), .fir_code(fir_code),
        .iir_amp_code(iir_amp_code), .iir_tc_code(iir_tc_code)
    );

    int   vectors = 0;
    int   fails = 0;
    bit   done = 0;
    exp_t q[$];

    int m_fir[4] = '{32, 32, 32, 32};
    int m_amp = 32, m_tc = 32;
    int a_fir[4] = '{0, 0, 0, 0};
    int a_amp = 0, a_tc = 0, c_fir = 0, c_iir = 0;

    function automatic logic [2:0] th(int l);
        case (l)
            0: return 3'b000;
            1: return 3'b001;
            2: return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    function automatic int lv(logic [2:0] t);
        return int'(t[0]) + int'(t[1]) + int'(t[2]);
    endfunction

    function automatic hist_t mk(int reflvl, bit mir, bit s1, bit s2, bit s3, bit s4);
        hist_t h;
        h[0] = th(mir ? 3 - reflvl : reflvl);
        h[1] = th(reflvl);
        h[2] = s1 ? 3'b111 : 3'b000;
        h[3] = s2 ? 3'b011 : 3'b001;
        h[4] = s3 ? 3'b111 : 3'b001;
        h[5] = s4 ? 3'b011 : 3'b000;
        return h;
    endfunction

    function automatic int step(int c, int acc);
        if (acc > 0 && c < 63) return c + 1;
        if (acc < 0 && c > 0) return c - 1;
        return c;
    endfunction

    // reference model written from R2..R10
    task automatic model(logic [3:0] e, logic [3:0][5:0][2:0] h);
        for (int k = 0; k < 4; k++) begin
            if (lv(h[k][0]) + lv(h[k][1]) == 3) begin
                bit res;
                res = e[k] ^ h[k][1][1];
                a_fir[k] += (res == h[k][2][1]) ? 1 : -1;
                a_amp    += (res == h[k][3][1]) ? 1 : -1;
                a_tc     += (res == h[k][4][1]) ? 1 : -1;
            end
        end
        c_fir++;
        c_iir++;
        if (c_fir == 256) begin
            for (int k = 0; k < 4; k++) begin
                m_fir[k] = step(m_fir[k], a_fir[k]);
                a_fir[k] = 0;
            end
            c_fir = 0;
        end
        if (c_iir == 256) begin
            m_amp = step(m_amp, a_amp);
            m_tc  = step(m_tc, a_tc);
            a_amp = 0;
            a_tc  = 0;
            c_iir = 0;
        end
    endtask

    task automatic push(string tag);
        exp_t x;
        for (int k = 0; k < 4; k++) x.fir[k] = m_fir[k];
        x.amp = m_amp;
        x.tc  = m_tc;
        x.tag = tag;
        q.push_back(x);
    endtask

    task automatic beat(bit v, logic [3:0] e, logic [3:0][5:0][2:0] h, string tag);
        @(negedge clk);
        in_valid  = v;
        edge_bits = e;
        dec_hist  = h;
        @(posedge clk);
        #1;
        if (v) model(e, h);
        push(tag);
    endtask

    task automatic chk(string tag, string what, int got, int exp);
        vectors++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            for (int k = 0; k < 4; k++) chk(x.tag, $sformatf("fir%0d", k), int'(fir_code[k]), x.fir[k]);
            chk(x.tag, "iir_amp", int'(iir_amp_code), x.amp);
            chk(x.tag, "iir_tc", int'(iir_tc_code), x.tc);
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0]           e;
        logic [3:0][5:0][2:0] h;

        // R1: reset values
        repeat (3) @(posedge clk);
        #1 push("R1 reset");
        @(negedge clk);
        rst = 1'b0;
        #1 push("R1 after reset");

        // R2 / R8: non-mirrored beats vote nothing; idle beats neither vote nor count
        for (int b = 0; b < 300; b++) begin
            for (int k = 0; k < 4; k++) begin
                h[k] = mk(b % 4, 1'b0, b[0], b[1], b[2], b[3]);
                e[k] = 1'b1;
            end
            beat(1'b1, e, h, "R2 non-mirror");
            if (b % 37 == 0) begin
                for (int k = 0; k < 4; k++) begin
                    h[k] = mk(1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
                    e[k] = 1'b0;
                end
                beat(1'b0, e, h, "R8 idle beat");
            end
        end

        // R3 R4 R5 R6 R7: per-slice directed correlation, three windows
        for (int b = 0; b < 768; b++) begin
            bit res;
            bit s;
            res = b[0] ^ b[3];
            for (int k = 0; k < 4; k++) begin
                int rl;
                rl = (b + k) % 4;
                case (k)
                    0: s = res;
                    1: s = !res;
                    default: s = b[1] ? res : !res;
                endcase
                h[k] = mk(rl, k != 3, s, res, !res, res);
                e[k] = res ^ (rl >= 2);
            end
            beat(1'b1, e, h, "R3/R4/R5/R6/R7 directed");
        end

        // R4 R6 R8 R9: random beats with idle gaps
        for (int b = 0; b < 1600; b++) begin
            for (int k = 0; k < 4; k++) begin
                h[k] = mk(int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
                          1'($urandom), 1'($urandom));
                e[k] = 1'($urandom);
            end
            beat(($urandom % 4) != 0, e, h, "R8/R9 random");
        end

        // R10: drive all codes up against 63, then down against 0
        for (int b = 0; b < 40 * 256; b++) begin
            bit res;
            res = 1'($urandom);
            for (int k = 0; k < 4; k++) begin
                h[k] = mk(k, 1'b1, res, res, res, !res);
                e[k] = res ^ (k >= 2);
            end
            beat(1'b1, e, h, "R10 ceiling");
        end
        for (int b = 0; b < 70 * 256; b++) begin
            bit res;
            res = 1'($urandom);
            for (int k = 0; k < 4; k++) begin
                h[k] = mk(3 - k, 1'b1, !res, !res, !res, res);
                e[k] = res ^ ((3 - k) >= 2);
            end
            beat(1'b1, e, h, "R10 floor");
        end

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule